// File: doc/BRIEF.md
# Memory-Mapped GPIO Bank with Input Inversion and Output Blink

This block is one bank of general-purpose I/O lines, sized by a parameter from 1 to 32 lines. Software reaches it over a simple 32-bit register bus with a request strobe, a write flag, a byte address and write data. Read data is registered and appears in the cycle after the read request. It stays on `bus_rdata` until the next read request.

Four registers hold per-line state: the output level, the direction, the blink enable and the input inversion. A fifth, read-only view returns the pad inputs after a two-flop synchronizer and a per-line XOR with the inversion bit. The same polarity-adjusted vector comes out on `line_level` for a separate interrupt block.

Output lines drive either their static output bit or a shared square wave. The square wave toggles every `BLINK_HALF` clock cycles from one free-running counter, so all blinking lines switch together. The bus is a single-cycle register interface with no back-pressure: every request completes in the cycle it is presented, and it has no valid/ready stream.

Top module: `gpio_bank`

## Requirements
- R1: While reset is held and right after it, the direction register reads all ones over the implemented lines, the output, blink and inversion registers read zero, and `pad_oe` is all zero.
- R2: A write with `bus_req`=1 and `bus_we`=1 updates the addressed register at that clock edge. A read with `bus_req`=1 and `bus_we`=0 loads `bus_rdata` at that edge. `bus_rdata` holds its value in cycles with no read request.
- R3: Register bits at positions `NUM_LINES` and above are not stored, and they read as zero at every address.
- R4: Line i is an output when direction bit i (register at 0x04) is 0, and then `pad_oe[i]`=1. A direction bit of 1 makes the line an input with `pad_oe[i]`=0.
- R5: When blink bit i (register at 0x08) is 0, `pad_out[i]` equals output register bit i (register at 0x00) in the cycle after the write.
- R6: When blink bit i is 1, `pad_out[i]` follows a square wave shared by all blinking lines, which toggles every `BLINK_HALF` cycles.
- R7: The input view (address 0x10) and `line_level` equal the pad level XOR the inversion bits (register at 0x0C). A pad change is visible two clock edges after it is applied, and an inversion change is visible after one edge.
- R8: Writes to 0x10 and to any address other than 0x00, 0x04, 0x08 and 0x0C change no register, and reads of those other addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_LINES | Asynchronous pad inputs |
| pad_out | output | NUM_LINES | Pad output levels |
| pad_oe | output | NUM_LINES | Pad output enables |
| line_level | output | NUM_LINES | Synchronized, polarity-adjusted inputs |

## Verification
The bench counts edges between a pad change and the input view. A design with one synchronizer stage too few or too many shows the new level a cycle early or late. Setting inversion bits must flip exactly the chosen lines; a design that inverts after the read mux, or not at all, returns the raw pad level. Blinking lines are sampled over several half-periods: an off-by-one counter gives intervals of `BLINK_HALF`±1, and per-line counters would let two blinking lines drift apart. Writes of all ones to the input view and to unused addresses, plus a 12-line build, catch a decoder that aliases addresses or stores bits above the implemented lines.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_OUT   = 3'd1,
    SEL_DIR   = 3'd2,
    SEL_BLINK = 3'd3,
    SEL_POL   = 3'd4,
    SEL_IN    = 3'd5
  } reg_sel_e;

  localparam logic [31:0] OFS_OUT   = 32'h00;
  localparam logic [31:0] OFS_DIR   = 32'h04;
  localparam logic [31:0] OFS_BLINK = 32'h08;
  localparam logic [31:0] OFS_POL   = 32'h0C;
  localparam logic [31:0] OFS_IN    = 32'h10;

  function automatic reg_sel_e decode_addr(input logic [31:0] a);
    reg_sel_e s;
    case (a)
      OFS_OUT:   s = SEL_OUT;
      OFS_DIR:   s = SEL_DIR;
      OFS_BLINK: s = SEL_BLINK;
      OFS_POL:   s = SEL_POL;
      OFS_IN:    s = SEL_IN;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/gpio_blink_timer.sv
module gpio_blink_timer #(
  parameter int HALF = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  reg_sel_e     sel,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] level,
  output logic [N-1:0] out_q,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] blink_q,
  output logic [N-1:0] pol_q,
  output logic [31:0]  rdata
);
  logic [N-1:0] rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_OUT:   out_q   <= wdata;
        SEL_DIR:   dir_q   <= wdata;
        SEL_BLINK: blink_q <= wdata;
        SEL_POL:   pol_q   <= wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_OUT:   rd_mux = out_q;
      SEL_DIR:   rd_mux = dir_q;
      SEL_BLINK: rd_mux = blink_q;
      SEL_POL:   rd_mux = pol_q;
      SEL_IN:    rd_mux = level;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= 32'(rd_mux);
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int BLINK_HALF = 12_500_000,
  parameter int ADDR_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_oe,
  output logic [NUM_LINES-1:0] line_level
);
  logic [NUM_LINES-1:0] sync_q;
  logic [NUM_LINES-1:0] out_q;
  logic [NUM_LINES-1:0] dir_q;
  logic [NUM_LINES-1:0] blink_q;
  logic [NUM_LINES-1:0] pol_q;
  logic                 phase;
  reg_sel_e             sel;

  assign sel = decode_addr(32'(bus_addr));

  gpio_sync #(.W(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q)
  );

  gpio_blink_timer #(.HALF(BLINK_HALF)) u_blink (
    .clk(clk), .rst_n(rst_n), .phase(phase)
  );

  gpio_regfile #(.N(NUM_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_req & bus_we), .rd_en(bus_req & ~bus_we),
    .sel(sel), .wdata(bus_wdata[NUM_LINES-1:0]), .level(line_level),
    .out_q(out_q), .dir_q(dir_q), .blink_q(blink_q), .pol_q(pol_q),
    .rdata(bus_rdata)
  );

  assign line_level = sync_q ^ pol_q;
  assign pad_oe     = ~dir_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign pad_out[i] = blink_q[i] ? phase : out_q[i];
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_req,
  input logic                 bus_we,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [NUM_LINES-1:0] pad_in,
  input logic [NUM_LINES-1:0] pad_out,
  input logic [NUM_LINES-1:0] pad_oe,
  input logic [NUM_LINES-1:0] line_level,
  input logic [NUM_LINES-1:0] out_q,
  input logic [NUM_LINES-1:0] dir_q,
  input logic [NUM_LINES-1:0] blink_q,
  input logic [NUM_LINES-1:0] pol_q
);
  localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(32'h00);
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(32'h04);
  localparam logic [ADDR_W-1:0] A_BLK = ADDR_W'(32'h08);
  localparam logic [ADDR_W-1:0] A_POL = ADDR_W'(32'h0C);
  localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(32'h10);

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end

  logic undef_addr;
  assign undef_addr = (bus_addr != A_OUT) && (bus_addr != A_DIR) &&
                      (bus_addr != A_BLK) && (bus_addr != A_POL) &&
                      (bus_addr != A_IN);

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> $stable(bus_rdata)); // R2

  AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == A_DIR) |=>
      pad_oe == ~$past(bus_wdata[NUM_LINES-1:0])); // R4

  AST_BLINK_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0) |->
      (((pad_out ^ $past(pad_out)) & blink_q & $past(blink_q)) == '0 ||
       ((pad_out ^ $past(pad_out)) & blink_q & $past(blink_q)) ==
         (blink_q & $past(blink_q)))); // R6

  AST_LEVEL_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> line_level == ($past(pad_in, 2) ^ pol_q)); // R7

  AST_INVIEW_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && (bus_addr == A_IN || undef_addr)) |=>
      ($stable(out_q) && $stable(dir_q) && $stable(blink_q) && $stable(pol_q))); // R8

  AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && undef_addr) |=> bus_rdata == 32'd0); // R8

  if (NUM_LINES < 32) begin : g_unimpl
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[31:NUM_LINES] == '0); // R3
  end
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .line_level(line_level), .out_q(out_q), .dir_q(dir_q),
  .blink_q(blink_q), .pol_q(pol_q)
);

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
  localparam int N = 12;
  localparam int H = 8;
  localparam int AW = 8;
  localparam logic [31:0] MASK = 32'h0000_0FFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out;
  logic [N-1:0]  pad_oe;
  logic [N-1:0]  line_level;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  gpio_bank #(.NUM_LINES(N), .BLINK_HALF(H), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .line_level(line_level)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 oe at reset", 32'(pad_oe), 32'h0);
    bus_rd(32'h00, d); check("R1 out reg", d, 32'h0);
    bus_rd(32'h04, d); check("R1 dir reg all inputs", d, MASK);
    bus_rd(32'h08, d); check("R1 blink reg", d, 32'h0);
    bus_rd(32'h0C, d); check("R1 pol reg", d, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_wr(32'h00, 32'h0000_0A5A);
    bus_rd(32'h00, d); check("R2 out readback", d, 32'h0A5A);
    repeat (3) @(negedge clk);
    check("R2 rdata holds without read", bus_rdata, 32'h0A5A);
    bus_wr(32'h0C, 32'hFFFF_FFFF);
    bus_rd(32'h0C, d); check("R3 upper bits read zero", d, MASK);
    bus_wr(32'h0C, 32'h0);
  endtask

  task automatic t_dir_out();
    bus_wr(32'h04, 32'h0000_0F0F);
    check("R4 oe from dir", 32'(pad_oe), 32'h0F0);
    bus_wr(32'h00, 32'h0000_00C3);
    check("R5 static pad_out", 32'(pad_out), 32'h0C3);
  endtask

  task automatic t_input();
    logic [31:0] d;
    @(negedge clk); pad_in = 12'h3C5;
    @(negedge clk);
    check("R7 one edge not yet visible", 32'(line_level), 32'h0);
    @(negedge clk);
    check("R7 visible after two edges", 32'(line_level), 32'h3C5);
    bus_rd(32'h10, d); check("R7 input view", d, 32'h3C5);
    bus_wr(32'h0C, 32'h0000_000F);
    check("R7 inversion applied", 32'(line_level), 32'h3CA);
    bus_rd(32'h10, d); check("R7 input view inverted", d, 32'h3CA);
    pad_in = 12'h000;
    @(negedge clk);
    check("R7 inverted one edge", 32'(line_level), 32'h3CA);
    @(negedge clk);
    check("R7 inverted two edges", 32'(line_level), 32'h00F);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    bus_wr(32'h10, 32'hFFFF_FFFF);
    bus_wr(32'h14, 32'hFFFF_FFFF);
    bus_wr(32'h02, 32'hFFFF_FFFF);
    bus_rd(32'h00, d); check("R8 out unchanged", d, 32'h0C3);
    bus_rd(32'h04, d); check("R8 dir unchanged", d, 32'hF0F);
    bus_rd(32'h08, d); check("R8 blink unchanged", d, 32'h0);
    bus_rd(32'h0C, d); check("R8 pol unchanged", d, 32'h00F);
    bus_rd(32'h14, d); check("R8 undefined read zero", d, 32'h0);
    bus_rd(32'h02, d); check("R8 unaligned read zero", d, 32'h0);
  endtask

  task automatic t_blink();
    logic prev;
    int last_tog = -1;
    int ntog = 0;
    int bad_int = 0;
    int bad_pair = 0;
    int bad_static = 0;
    bus_wr(32'h04, 32'h0);
    bus_wr(32'h00, 32'h0);
    bus_wr(32'h08, 32'h0000_0006);
    prev = pad_out[1];
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (pad_out[2] !== pad_out[1]) bad_pair++;
      if ((32'(pad_out) & ~32'h6) != 32'h0) bad_static++;
      if (pad_out[1] !== prev) begin
        if (last_tog >= 0 && (c - last_tog) != H) bad_int++;
        last_tog = c;
        ntog++;
      end
      prev = pad_out[1];
    end
    check("R6 toggle count over 60 cycles", 32'(ntog >= 6), 32'h1);
    check("R6 half-period intervals", 32'(bad_int), 32'h0);
    check("R6 blinking lines in lockstep", 32'(bad_pair), 32'h0);
    check("R5 non-blinking lines static", 32'(bad_static), 32'h0);
    bus_wr(32'h08, 32'h0);
    bus_wr(32'h00, 32'h0000_0006);
    check("R5 static after blink off", 32'(pad_out), 32'h006);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_dir_out();
    t_input();
    t_ignore();
    t_blink();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule